// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds seven interrupt flags and seven matching enable bits behind a small byte-wide register port, and drives one interrupt line to a processor. Event sources (shift-register completion, shift byte and shift clock events, and two timers) pulse their own input bit to set a flag. Software clears flags by writing ones to them in the flag register. Software changes enables through one register whose top data bit chooses between setting and clearing the selected bits, so no read-modify-write is needed.

Reading the flag register returns the seven flags plus a computed "something enabled is pending" bit on top. Reading the shift-data register returns the byte presented by the shift logic and, as a side effect, acknowledges the three shift-related flags. The interrupt line only follows a fixed subset of the flags (shift complete and both timers). The other flags can be polled and still feed the summary bit.

The register port is decoded from a two-bit select: 0 flag register, 1 enable register, 2 shift-data register, 3 unused. Read data is combinational from the current select and state, and side effects take place at the clock edge that ends the access.

Top module: `ifu_top`

## Requirements
- R1: After reset, all flags and enables are 0, `irq` is 0, a flag read returns 0x00 and an enable read returns 0x80.
- R2: A 1 on `src_set[i]` sets flag i at the next clock edge. The bit positions are 2 shift complete, 3 shift byte, 4 shift clock, 5 timer B, 6 timer A, and 0 and 1 spare.
- R3: A write to select 0 clears, at the next edge, every flag whose `bus_wdata` bit in [6:0] is 1, and leaves the others unchanged.
- R4: When a source sets a flag in the same cycle as a clear of that flag, whether by a flag write or by a shift-data read, the flag ends up set.
- R5: A write to select 1 with `bus_wdata[7]`=1 ORs `bus_wdata[6:0]` into the enables.
- R6: A write to select 1 with `bus_wdata[7]`=0 clears each enable whose `bus_wdata[6:0]` bit is 1.
- R7: A read of select 0 returns the flags in [6:0], and in bit 7 a 1 exactly when some flag is both set and enabled.
- R8: A read of select 1 returns 1 in bit 7 and the enables in [6:0].
- R9: A read of select 2 returns `shift_byte` and clears flags 2, 3 and 4 (mask 0x1C) at the next edge. The other flags are left unchanged.
- R10: `irq` is 1 exactly when (flags & enables & 0x64) is nonzero. Flags 0, 1, 3 and 4 never raise it.
- R11: Select 3 reads 0x00 and ignores writes. `bus_rdata` is 0x00 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (0 flag, 1 enable, 2 shift data, 3 unused) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| shift_byte | input | 8 | Byte returned by a shift-data read |
| src_set | input | 7 | One set pulse per flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a source setting a flag and software clearing that same flag. The clear can come from a flag-register write or from a shift-data read. The bench provokes both collisions on purpose, drives random mixes of pulses and accesses, and judges every cycle against a behavioural model that applies the clear first and the set last. The expected result is that the flag stays set and that `irq` and the summary bit follow it.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int FLAG_BITS = 7;
    localparam int BUS_BITS  = FLAG_BITS + 1;

    // Flags routed to the interrupt line: shift complete, timer B, timer A.
    localparam logic [FLAG_BITS-1:0] IRQ_ROUTE  = 7'h64;
    // Flags acknowledged by a shift-data read.
    localparam logic [FLAG_BITS-1:0] SHIFT_ACK  = 7'h1C;

    typedef enum logic [1:0] {
        SEL_FLAG  = 2'd0,
        SEL_ENAB  = 2'd1,
        SEL_SHIFT = 2'd2,
        SEL_NONE  = 2'd3
    } sel_t;

endpackage

// File: rtl/ifu_flag_bank.sv
module ifu_flag_bank #(
    parameter int                 N        = 7,
    parameter logic [N-1:0]       ACK_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] wr_clr_i,
    input  logic         rd_ack_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        logic clr;

        assign clr = wr_clr_i[i] | (rd_ack_i & ACK_MASK[i]);

        // A set on the same edge as a clear wins.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr) begin
                bit_q <= 1'b0;
            end
        end

        assign flags_o[i] = bit_q;
    end

endmodule

// File: rtl/ifu_enable_bank.sv
module ifu_enable_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         set_mode_i,
    input  logic [N-1:0] bits_i,
    output logic [N-1:0] en_o
);

    logic [N-1:0] en_q;
    logic [N-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            if (set_mode_i) begin
                en_d = en_q | bits_i;
            end else begin
                en_d = en_q & ~bits_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/ifu_read_mux.sv
module ifu_read_mux
    import ifu_pkg::*;
#(
    parameter int N  = 7,
    parameter int DW = N + 1
) (
    input  logic          rd_i,
    input  sel_t          sel_i,
    input  logic [N-1:0]  flags_i,
    input  logic [N-1:0]  en_i,
    input  logic [DW-1:0] shift_i,
    output logic [DW-1:0] rdata_o
);

    logic any_pending;

    assign any_pending = |(flags_i & en_i);

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel_i)
                SEL_FLAG:  rdata_o = {any_pending, flags_i};
                SEL_ENAB:  rdata_o = {1'b1, en_i};
                SEL_SHIFT: rdata_o = shift_i;
                SEL_NONE:  rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/ifu_irq_reduce.sv
module ifu_irq_reduce #(
    parameter int           N     = 7,
    parameter logic [N-1:0] ROUTE = '1
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    assign irq_o = |(flags_i & en_i & ROUTE);

endmodule

// File: rtl/ifu_top.sv
module ifu_top
    import ifu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs,
    input  logic                 bus_we,
    input  logic [1:0]           bus_addr,
    input  logic [BUS_BITS-1:0]  bus_wdata,
    output logic [BUS_BITS-1:0]  bus_rdata,
    input  logic [BUS_BITS-1:0]  shift_byte,
    input  logic [FLAG_BITS-1:0] src_set,
    output logic                 irq
);

    sel_t                 sel;
    logic                 wr_flag;
    logic                 wr_enab;
    logic                 rd_any;
    logic                 rd_shift;
    logic [FLAG_BITS-1:0] wr_clr;
    logic [FLAG_BITS-1:0] flags_q;
    logic [FLAG_BITS-1:0] en_q;

    assign sel = sel_t'(bus_addr);

    always_comb begin
        wr_flag  = 1'b0;
        wr_enab  = 1'b0;
        rd_shift = 1'b0;
        rd_any   = bus_cs & ~bus_we;
        unique case (sel)
            SEL_FLAG:  wr_flag  = bus_cs & bus_we;
            SEL_ENAB:  wr_enab  = bus_cs & bus_we;
            SEL_SHIFT: rd_shift = bus_cs & ~bus_we;
            SEL_NONE:  ;
        endcase
    end

    assign wr_clr = wr_flag ? bus_wdata[FLAG_BITS-1:0] : '0;

    ifu_flag_bank #(
        .N        (FLAG_BITS),
        .ACK_MASK (SHIFT_ACK)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (src_set),
        .wr_clr_i (wr_clr),
        .rd_ack_i (rd_shift),
        .flags_o  (flags_q)
    );

    ifu_enable_bank #(
        .N (FLAG_BITS)
    ) u_enab (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_enab),
        .set_mode_i (bus_wdata[BUS_BITS-1]),
        .bits_i     (bus_wdata[FLAG_BITS-1:0]),
        .en_o       (en_q)
    );

    ifu_read_mux #(
        .N  (FLAG_BITS),
        .DW (BUS_BITS)
    ) u_rmux (
        .rd_i    (rd_any),
        .sel_i   (sel),
        .flags_i (flags_q),
        .en_i    (en_q),
        .shift_i (shift_byte),
        .rdata_o (bus_rdata)
    );

    ifu_irq_reduce #(
        .N     (FLAG_BITS),
        .ROUTE (IRQ_ROUTE)
    ) u_irq (
        .flags_i (flags_q),
        .en_i    (en_q),
        .irq_o   (irq)
    );

endmodule

// File: rtl/ifu_checker.sv
module ifu_checker
    import ifu_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_cs,
    input logic                 bus_we,
    input logic [1:0]           bus_addr,
    input logic [BUS_BITS-1:0]  bus_wdata,
    input logic [FLAG_BITS-1:0] src_set,
    input logic [FLAG_BITS-1:0] flags,
    input logic [FLAG_BITS-1:0] en,
    input logic                 irq
);

    assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_set) |=> ((flags & $past(src_set)) == $past(src_set)));

    assert_wr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_we && bus_addr == 2'd0)
        |=> ((flags & $past(bus_wdata[FLAG_BITS-1:0]) & ~$past(src_set)) == '0));

    assert_en_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_we && bus_addr == 2'd1 && bus_wdata[BUS_BITS-1])
        |=> ((en & $past(bus_wdata[FLAG_BITS-1:0])) == $past(bus_wdata[FLAG_BITS-1:0])));

    assert_en_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_we && bus_addr == 2'd1 && !bus_wdata[BUS_BITS-1])
        |=> ((en & $past(bus_wdata[FLAG_BITS-1:0])) == '0));

    assert_shift_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && bus_addr == 2'd2)
        |=> ((flags & SHIFT_ACK & ~$past(src_set)) == '0));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|(src_set & IRQ_ROUTE))
                        || $past(bus_cs && bus_we && bus_addr == 2'd1)));

endmodule

bind ifu_top ifu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_set   (src_set),
    .flags     (flags_q),
    .en        (en_q),
    .irq       (irq)
);

// File: tb/tb_ifu_top.sv
module tb_ifu_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] shift_byte = 8'h00;
    logic [6:0] src_set = 7'h00;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [6:0] m_flag = 7'h00;
    logic [6:0] m_en = 7'h00;

    always #2 clk = ~clk;

    ifu_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cs     (bus_cs),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .shift_byte (shift_byte),
        .src_set    (src_set),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic cs, input logic we, input logic [1:0] a);
        if (!cs || we) return 8'h00;
        case (a)
            2'd0: return {|(m_flag & m_en), m_flag};
            2'd1: return {1'b1, m_en};
            2'd2: return shift_byte;
            default: return 8'h00;
        endcase
    endfunction

    // One bus cycle: drive, compare outputs, clock, update model.
    task automatic step(input logic cs, input logic we, input logic [1:0] a,
                        input logic [7:0] wd, input logic [6:0] src, input string tag);
        logic [6:0] clr;
        bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = wd; src_set = src;
        #1;
        chk({tag, " R10 irq"}, {7'h00, irq}, {7'h00, |(m_flag & m_en & 7'h64)});
        chk({tag, " rdata"}, bus_rdata, exp_rdata(cs, we, a));
        @(posedge clk);
        clr = 7'h00;
        if (cs && we && a == 2'd0) clr = wd[6:0];
        if (cs && !we && a == 2'd2) clr = 7'h1C;
        m_flag = (m_flag & ~clr) | src;
        if (cs && we && a == 2'd1) m_en = wd[7] ? (m_en | wd[6:0]) : (m_en & ~wd[6:0]);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 2'd0, 8'h00, 7'h00, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        step(1'b1, 1'b0, a, 8'h00, 7'h00, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b1, a, d, 7'h00, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        idle("R1 reset");
        rd(2'd0, "R1 flag read after reset");
        rd(2'd1, "R1 enable read after reset");
        chk("R1 direct rdata enable", {1'b1, m_en}, 8'h80);

        // Enable everything, read back
        wr(2'd1, 8'hFF, "R5 enable set all");
        rd(2'd1, "R8 enable read");

        // Spare flag: visible and summary but no irq
        step(1'b0, 1'b0, 2'd0, 8'h00, 7'h01, "R2 spare source");
        rd(2'd0, "R7 summary from spare flag");
        idle("R10 spare flag no irq");

        // Timer A source raises irq
        step(1'b0, 1'b0, 2'd0, 8'h00, 7'h40, "R2 timer A source");
        idle("R10 timer A irq");
        rd(2'd0, "R2 flag read shows timer A");

        // Write-one-to-clear
        wr(2'd0, 8'h40, "R3 clear timer A");
        rd(2'd0, "R3 flag after clear");

        // Enable clear mode
        wr(2'd1, 8'h60, "R6 clear enables 5 and 6");
        rd(2'd1, "R6 enable read after clear");
        step(1'b0, 1'b0, 2'd0, 8'h00, 7'h20, "R10 timer B with enable off");
        idle("R10 masked timer B");
        wr(2'd1, 8'hA0, "R5 re-enable timer B");
        idle("R10 timer B irq");

        // Shift-data read acknowledges shift flags only
        step(1'b0, 1'b0, 2'd0, 8'h00, 7'h1C, "R2 shift sources");
        rd(2'd0, "R7 flags before ack");
        shift_byte = 8'hA5;
        rd(2'd2, "R9 shift read data");
        rd(2'd0, "R9 flags after ack");

        // Collisions
        shift_byte = 8'h3C;
        step(1'b1, 1'b0, 2'd2, 8'h00, 7'h04, "R4 set vs read ack");
        rd(2'd0, "R4 shift flag survived ack");
        step(1'b1, 1'b1, 2'd0, 8'h01, 7'h01, "R4 set vs write clear");
        rd(2'd0, "R4 spare flag survived clear");

        // Unused select
        wr(2'd3, 8'hFF, "R11 write unused");
        rd(2'd3, "R11 read unused");
        rd(2'd0, "R11 flags unchanged");
        rd(2'd1, "R11 enables unchanged");

        // Summary bit off when all enables cleared
        wr(2'd1, 8'h7F, "R6 clear all enables");
        rd(2'd0, "R7 summary off");

        // Random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            shift_byte = lfsr[15:8];
            step(lfsr[0], lfsr[1], lfsr[3:2], lfsr[11:4],
                 (lfsr[12] ? lfsr[15:9] : 7'h00), "R4 R10 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule